// File: doc/BRIEF.md
# Eight-Lane Half-Precision Vector Adder

This block adds two 128-bit vectors of IEEE 754 binary16 numbers, eight lanes at a time, and hands back a 128-bit sum one clock after an input strobe. It sits behind an operand read stage of a SIMD execution pipe: the pipe presents both source vectors, a mode bit, a rounding mode and a trap-enable mask, and picks up the result and the exception report on the next cycle.

Two lane pairings are offered. In lane-wise mode each lane of operand A is added to the same lane of operand B. In pairwise mode the two operands are joined into one 256-bit value, operand B above operand A, and neighbouring 16-bit elements of that value are added, so the low four result lanes reduce operand A and the high four reduce operand B.

Each addition may raise invalid, overflow, underflow or inexact. Every raised exception whose trap-enable bit is clear is ORed into a sticky flag register; every raised exception whose enable bit is set requests a trap instead. The block produces no integer condition codes.

Top module: `hvec_add8`

## Requirements
- R1: In lane-wise mode (`pair_mode_i`=0), result bits [16i+15:16i] are the binary16 sum (1 sign, 5 exponent bits with bias 15, 10 fraction bits) of operand A bits [16i+15:16i] and operand B bits [16i+15:16i], for i = 0..7.
- R2: In pairwise mode (`pair_mode_i`=1), with C = {operand B, operand A} (256 bits), result lane e is the sum of C element 2e and C element 2e+1, for e = 0..7.
- R3: `rmode_i` selects rounding for all lanes: 0 nearest with ties to even, 1 toward +infinity, 2 toward -infinity, 3 toward zero.
- R4: Subnormal operands and results are computed exactly, without being flushed to zero.
- R5: A sum that is exactly zero is +0, except that it is -0 when both operands are -0 or when operands of opposite sign cancel under rounding mode 2; +0 plus +0 is +0 in every mode.
- R6: Any NaN operand gives 0x7E00; a signaling NaN operand (exponent all ones, fraction nonzero, fraction bit 9 clear) or the sum of +infinity and -infinity raises invalid and also gives 0x7E00. Infinity plus a finite value returns that infinity with no exception.
- R7: A rounded magnitude whose exponent would reach 31 raises overflow and inexact; the result is infinity of the sum's sign when the mode rounds away from zero for that sign (mode 0, mode 1 positive, mode 2 negative) and the largest finite value 0x7BFF with that sign otherwise.
- R8: Exceptions use bit 0 invalid, bit 1 overflow, bit 2 underflow (tiny before rounding and inexact), bit 3 inexact; the exceptions of all eight lanes of a strobed operation whose `trap_en_i` bit is clear are ORed into `flags_o`, which only reset clears and which is unchanged by cycles without a strobe.
- R9: `trap_o` is high for exactly the cycle in which a result is presented if any exception raised by that operation has its `trap_en_i` bit set; such exceptions do not reach `flags_o`.
- R10: After reset `out_valid_o`, `flags_o`, `trap_o` and `sum_o` are zero; `out_valid_o` and the result follow `in_valid_i` by exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Operands and controls are valid this cycle |
| pair_mode_i | input | 1 | 0 lane-wise, 1 pairwise over {B, A} |
| rmode_i | input | 2 | Rounding mode, encoding in R3 |
| trap_en_i | input | 4 | Per-exception trap enable, bit order as in R8 |
| opa_i | input | 128 | Operand A, eight binary16 lanes |
| opb_i | input | 128 | Operand B, eight binary16 lanes |
| out_valid_o | output | 1 | Result valid |
| sum_o | output | 128 | Eight binary16 sums |
| flags_o | output | 4 | Sticky exception flags |
| trap_o | output | 1 | Trap request for the presented result |

## Verification
The bench goes after the rounding tie 1 + 2^-11 under all four modes, where a design that rounds on magnitude instead of on sign in the directed modes returns the wrong neighbour for negative sums. It pushes sums across the subnormal/normal boundary (0x03FF + 0x0001) and between subnormals, where a flushing or misaligned design yields zero or a wrong exponent field, and cancels equal magnitudes to catch a zero of the wrong sign. It drives overflow in every mode, signaling and quiet NaNs and opposing infinities, so that a design that saturates in the wrong mode, forwards a NaN payload or misses invalid is exposed. Trap-enabled cases check that a trapped exception pulses the trap and stays out of the sticky flags, and random lanes in both pairings compare against an exact integer-scaled reference.

// File: rtl/hvec_pkg.sv
package hvec_pkg;

  localparam int HW   = 16;
  localparam int EW   = 5;
  localparam int FW   = 10;
  localparam int NFLG = 4;

  localparam int FLG_INV = 0;
  localparam int FLG_OVF = 1;
  localparam int FLG_UNF = 2;
  localparam int FLG_INX = 3;

  localparam logic [1:0] RND_NEAR = 2'd0;
  localparam logic [1:0] RND_UP   = 2'd1;
  localparam logic [1:0] RND_DOWN = 2'd2;
  localparam logic [1:0] RND_ZERO = 2'd3;

  localparam logic [HW-1:0] QNAN_DEF = 16'h7E00;
  localparam logic [HW-2:0] MAX_MAG  = 15'h7BFF;
  localparam logic [HW-2:0] INF_MAG  = 15'h7C00;

endpackage

// File: rtl/hvec_pair_route.sv
module hvec_pair_route #(
  parameter int LANES = 8,
  parameter int LW    = 16
) (
  input  logic [LANES*LW-1:0] a_i,
  input  logic [LANES*LW-1:0] b_i,
  input  logic                pair_i,
  output logic [LANES*LW-1:0] x_o,
  output logic [LANES*LW-1:0] y_o
);
  localparam int VW = LANES * LW;

  logic [2*VW-1:0] joined;
  assign joined = {b_i, a_i};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign x_o[l*LW +: LW] = pair_i ? joined[(2*l)*LW +: LW]   : a_i[l*LW +: LW];
    assign y_o[l*LW +: LW] = pair_i ? joined[(2*l+1)*LW +: LW] : b_i[l*LW +: LW];
  end

endmodule

// File: rtl/hvec_lane_add.sv
module hvec_lane_add
  import hvec_pkg::*;
(
  input  logic [HW-1:0]   x_i,
  input  logic [HW-1:0]   y_i,
  input  logic [1:0]      rm_i,
  output logic [HW-1:0]   z_o,
  output logic [NFLG-1:0] exc_o
);
  localparam int MW  = FW + 1;
  localparam int XW  = MW + 3;
  localparam int SW  = XW + 1;
  localparam int XEW = EW + 1;
  localparam int LZW = $clog2(XW + 1);
  localparam logic [EW-1:0]  EMAX  = {EW{1'b1}};
  localparam logic [EW-1:0]  DCAP  = EW'(XW + 1);
  localparam logic [XEW-1:0] EOVF  = {1'b0, EMAX};

  function automatic logic [LZW-1:0] lead_zeros(input logic [XW-1:0] v);
    logic [LZW-1:0] n;
    n = LZW'(XW);
    for (int i = 0; i < XW; i++) begin
      if (v[i]) n = LZW'(XW - 1 - i);
    end
    return n;
  endfunction

  // operand classification
  logic [EW-1:0] xe, ye;
  logic [FW-1:0] xf, yf;
  logic x_nan, y_nan, x_snan, y_snan, x_inf, y_inf;

  assign xe     = x_i[HW-2 -: EW];
  assign ye     = y_i[HW-2 -: EW];
  assign xf     = x_i[FW-1:0];
  assign yf     = y_i[FW-1:0];
  assign x_nan  = (xe == EMAX) && (xf != '0);
  assign y_nan  = (ye == EMAX) && (yf != '0);
  assign x_snan = x_nan && !xf[FW-1];
  assign y_snan = y_nan && !yf[FW-1];
  assign x_inf  = (xe == EMAX) && (xf == '0);
  assign y_inf  = (ye == EMAX) && (yf == '0);

  // order by magnitude
  logic          x_big;
  logic [HW-1:0] big_h, sml_h;
  logic [EW-1:0] big_e, sml_e, shift_d, dcap;
  logic [MW-1:0] big_m, sml_m;

  assign x_big = (x_i[HW-2:0] >= y_i[HW-2:0]);
  assign big_h = x_big ? x_i : y_i;
  assign sml_h = x_big ? y_i : x_i;
  assign big_e = (big_h[HW-2 -: EW] == '0) ? EW'(1) : big_h[HW-2 -: EW];
  assign sml_e = (sml_h[HW-2 -: EW] == '0) ? EW'(1) : sml_h[HW-2 -: EW];
  assign big_m = {big_h[HW-2 -: EW] != '0, big_h[FW-1:0]};
  assign sml_m = {sml_h[HW-2 -: EW] != '0, sml_h[FW-1:0]};
  assign shift_d = big_e - sml_e;
  assign dcap    = (shift_d > DCAP) ? DCAP : shift_d;

  // align smaller operand, collapse lost bits into sticky
  logic [2*XW-1:0] sh_wide;
  logic [XW-1:0]   al;
  logic            eff_sub;
  logic [SW-1:0]   sum;

  assign sh_wide = {sml_m, {(2*XW-MW){1'b0}}} >> dcap;
  assign al      = {sh_wide[2*XW-1:XW+1], sh_wide[XW] | (|sh_wide[XW-1:0])};
  assign eff_sub = big_h[HW-1] ^ sml_h[HW-1];
  assign sum     = eff_sub ? ({1'b0, big_m, 3'b000} - {1'b0, al})
                           : ({1'b0, big_m, 3'b000} + {1'b0, al});

  // normalize
  logic [LZW-1:0] lz;
  logic [EW-1:0]  lim, shamt;
  logic [XW-1:0]  nm;
  logic [XEW-1:0] nexp;

  always_comb begin
    lz    = lead_zeros(sum[XW-1:0]);
    lim   = big_e - EW'(1);
    shamt = '0;
    if (sum[SW-1]) begin
      nm   = {sum[SW-1:2], sum[1] | sum[0]};
      nexp = {1'b0, big_e} + XEW'(1);
    end else begin
      shamt = (EW'(lz) < lim) ? EW'(lz) : lim;
      nm    = sum[XW-1:0] << shamt;
      nexp  = {1'b0, big_e} - {1'b0, shamt};
    end
  end

  // round
  logic           res_s, g_bit, rs_bit, inx, inc, tiny, ovf;
  logic [MW:0]    mr;
  logic [MW-1:0]  fm;
  logic [XEW-1:0] fexp;

  assign res_s  = big_h[HW-1];
  assign g_bit  = nm[2];
  assign rs_bit = nm[1] | nm[0];
  assign inx    = g_bit | rs_bit;

  always_comb begin
    unique case (rm_i)
      RND_NEAR: inc = g_bit & (rs_bit | nm[3]);
      RND_UP:   inc = inx & ~res_s;
      RND_DOWN: inc = inx & res_s;
      default:  inc = 1'b0;
    endcase
  end

  assign mr   = {1'b0, nm[XW-1:3]} + (MW+1)'(inc);
  assign fm   = mr[MW] ? mr[MW:1] : mr[MW-1:0];
  assign fexp = mr[MW] ? nexp + XEW'(1) : nexp;
  assign tiny = !nm[XW-1];
  assign ovf  = (fexp >= EOVF);

  // assemble with special cases
  logic to_inf;
  assign to_inf = (rm_i == RND_NEAR) || ((rm_i == RND_UP) && !res_s) ||
                  ((rm_i == RND_DOWN) && res_s);

  always_comb begin
    exc_o = '0;
    if (x_nan || y_nan) begin
      z_o            = QNAN_DEF;
      exc_o[FLG_INV] = x_snan | y_snan;
    end else if (x_inf && y_inf && (x_i[HW-1] != y_i[HW-1])) begin
      z_o            = QNAN_DEF;
      exc_o[FLG_INV] = 1'b1;
    end else if (x_inf) begin
      z_o = x_i;
    end else if (y_inf) begin
      z_o = y_i;
    end else if (sum == '0) begin
      z_o = {eff_sub ? (rm_i == RND_DOWN) : res_s, {(HW-1){1'b0}}};
    end else if (ovf) begin
      z_o            = {res_s, to_inf ? INF_MAG : MAX_MAG};
      exc_o[FLG_OVF] = 1'b1;
      exc_o[FLG_INX] = 1'b1;
    end else begin
      z_o            = {res_s, fm[MW-1] ? fexp[EW-1:0] : EW'(0), fm[FW-1:0]};
      exc_o[FLG_INX] = inx;
      exc_o[FLG_UNF] = tiny & inx;
    end
  end

endmodule

// File: rtl/hvec_add8.sv
module hvec_add8
  import hvec_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid_i,
  input  logic                  pair_mode_i,
  input  logic [1:0]            rmode_i,
  input  logic [3:0]            trap_en_i,
  input  logic [LANES*16-1:0]   opa_i,
  input  logic [LANES*16-1:0]   opb_i,
  output logic                  out_valid_o,
  output logic [LANES*16-1:0]   sum_o,
  output logic [3:0]            flags_o,
  output logic                  trap_o
);
  localparam int VW = LANES * HW;

  logic [VW-1:0]   x_vec, y_vec, z_vec;
  logic [NFLG-1:0] lane_exc [LANES];
  logic [NFLG-1:0] exc_any;

  hvec_pair_route #(.LANES(LANES), .LW(HW)) u_route (
    .a_i    (opa_i),
    .b_i    (opb_i),
    .pair_i (pair_mode_i),
    .x_o    (x_vec),
    .y_o    (y_vec)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_add
    hvec_lane_add u_add (
      .x_i   (x_vec[l*HW +: HW]),
      .y_i   (y_vec[l*HW +: HW]),
      .rm_i  (rmode_i),
      .z_o   (z_vec[l*HW +: HW]),
      .exc_o (lane_exc[l])
    );
  end

  always_comb begin
    exc_any = '0;
    for (int l = 0; l < LANES; l++) exc_any = exc_any | lane_exc[l];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      sum_o       <= '0;
      flags_o     <= '0;
      trap_o      <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      trap_o      <= in_valid_i & (|(exc_any & trap_en_i));
      if (in_valid_i) begin
        sum_o   <= z_vec;
        flags_o <= flags_o | (exc_any & ~trap_en_i);
      end
    end
  end

endmodule

// File: rtl/hvec_add8_chk.sv
module hvec_add8_chk #(
  parameter int LANES = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid_i,
  input logic [3:0]          trap_en_i,
  input logic                out_valid_o,
  input logic [LANES*16-1:0] sum_o,
  input logic [3:0]          flags_o,
  input logic                trap_o
);
  logic odd_nan;
  always_comb begin
    odd_nan = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (sum_o[l*16+10 +: 5] == 5'h1F && sum_o[l*16 +: 10] != 10'd0 &&
          sum_o[l*16 +: 16] != 16'h7E00)
        odd_nan = 1'b1;
    end
  end

  assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid_i |=> out_valid_o);
  assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid_i |=> !out_valid_o);
  assert_trap_with_result_R9: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> out_valid_o);
  assert_trap_needs_enable_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && trap_en_i == 4'd0) |=> !trap_o);
  assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
  assert_flags_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid_i |=> $stable(flags_o));
  assert_default_nan_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> !odd_nan);

endmodule

bind hvec_add8 hvec_add8_chk #(.LANES(LANES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid_i  (in_valid_i),
  .trap_en_i   (trap_en_i),
  .out_valid_o (out_valid_o),
  .sum_o       (sum_o),
  .flags_o     (flags_o),
  .trap_o      (trap_o)
);

// File: tb/test_hvec_add8.sv
`timescale 1ns/1ps
module test_hvec_add8;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         pair_mode = 1'b0;
  logic [1:0]   rmode = 2'd0;
  logic [3:0]   trap_en = 4'd0;
  logic [127:0] opa = '0, opb = '0;
  logic         out_valid;
  logic [127:0] sum;
  logic [3:0]   flags;
  logic         trap;

  int nchk = 0;
  int nfail = 0;
  logic done = 1'b0;
  logic [3:0] flag_model = 4'd0;

  typedef struct {
    logic [127:0] res;
    logic [3:0]   flg;
    logic         trp;
    string        tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  hvec_add8 i_hvec_add8 (
    .clk(clk), .rst(rst), .in_valid_i(in_valid), .pair_mode_i(pair_mode),
    .rmode_i(rmode), .trap_en_i(trap_en), .opa_i(opa), .opb_i(opb),
    .out_valid_o(out_valid), .sum_o(sum), .flags_o(flags), .trap_o(trap)
  );

  // exact reference: values scaled by 2^24 as integers
  function automatic longint to_fix(input logic [15:0] h);
    longint m;
    if (h[14:10] == 5'd0) m = longint'(h[9:0]);
    else m = longint'({1'b1, h[9:0]}) << (h[14:10] - 1);
    return h[15] ? -m : m;
  endfunction

  function automatic logic [15:0] ref_add(input logic [15:0] x, input logic [15:0] y,
                                          input logic [1:0] rm, output logic [3:0] fl);
    logic xn, yn, xi, yi, neg, up;
    longint s, m, q, rem, half;
    int msb, k, e;
    fl = 4'd0;
    xn = (x[14:10] == 5'h1F) && (x[9:0] != 0);
    yn = (y[14:10] == 5'h1F) && (y[9:0] != 0);
    xi = (x[14:0] == 15'h7C00);
    yi = (y[14:0] == 15'h7C00);
    if (xn || yn) begin
      if ((xn && !x[9]) || (yn && !y[9])) fl[0] = 1'b1;
      return 16'h7E00;
    end
    if (xi && yi && x[15] != y[15]) begin fl[0] = 1'b1; return 16'h7E00; end
    if (xi) return x;
    if (yi) return y;
    s = to_fix(x) + to_fix(y);
    if (s == 0) return (x[15] == y[15]) ? {x[15], 15'd0} : {rm == 2'd2, 15'd0};
    neg = (s < 0);
    m = neg ? -s : s;
    msb = 0;
    for (int i = 0; i < 63; i++) if (m[i]) msb = i;
    k = (msb > 10) ? msb - 10 : 0;
    q = m >> k;
    rem = m & ((64'sd1 << k) - 1);
    half = (k > 0) ? (64'sd1 << (k - 1)) : 64'sd0;
    case (rm)
      2'd0: up = (rem > half) || (rem == half && rem != 0 && q[0]);
      2'd1: up = (rem != 0) && !neg;
      2'd2: up = (rem != 0) && neg;
      default: up = 1'b0;
    endcase
    if (rem != 0) fl[3] = 1'b1;
    if (k == 0 && q < 1024 && rem != 0) fl[2] = 1'b1;
    q = q + (up ? 1 : 0);
    if (q == 2048) begin q = 1024; k = k + 1; end
    if (k == 0 && q < 1024) return {neg, 5'd0, q[9:0]};
    e = k + 1;
    if (e >= 31) begin
      fl[1] = 1'b1; fl[3] = 1'b1;
      if (rm == 2'd0 || (rm == 2'd1 && !neg) || (rm == 2'd2 && neg))
        return {neg, 15'h7C00};
      return {neg, 15'h7BFF};
    end
    return {neg, e[4:0], q[9:0]};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // driver: called at a negedge, leaves in_valid high for one cycle
  task automatic drive(input logic mode, input logic [1:0] rm, input logic [3:0] ten,
                       input logic [127:0] a, input logic [127:0] b, input string tag);
    exp_t it;
    logic [255:0] cat;
    logic [15:0] x, y;
    logic [3:0] fl, raised;
    cat = {b, a};
    raised = 4'd0;
    for (int l = 0; l < 8; l++) begin
      x = mode ? cat[32*l +: 16] : a[16*l +: 16];
      y = mode ? cat[32*l+16 +: 16] : b[16*l +: 16];
      it.res[16*l +: 16] = ref_add(x, y, rm, fl);
      raised = raised | fl;
    end
    flag_model = flag_model | (raised & ~ten);
    it.flg = flag_model;
    it.trp = |(raised & ten);
    it.tag = tag;
    sb.push_back(it);
    in_valid = 1'b1; pair_mode = mode; rmode = rm; trap_en = ten; opa = a; opb = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        nchk++; nfail++;
        $display("FAIL R10 unexpected result: actual %h expected none", sum);
      end else begin
        exp_t it;
        it = sb.pop_front();
        check(it.tag, "sum", sum, it.res);
        check("R8", "flags", 128'(flags), 128'(it.flg));
        check("R9", "trap", 128'(trap), 128'(it.trp));
      end
    end
  end

  function automatic logic [127:0] rep(input logic [15:0] h);
    return {8{h}};
  endfunction

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [127:0] a, b;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10", "valid after reset", 128'(out_valid), 128'd0);
    check("R10", "flags after reset", 128'(flags), 128'd0);
    check("R10", "sum after reset", sum, 128'd0);
    check("R10", "trap after reset", 128'(trap), 128'd0);

    // R1 exact lane-wise sums, distinct lanes
    a = {16'h3C00, 16'h4000, 16'hC000, 16'h3800, 16'h5640, 16'h0000, 16'h4400, 16'hB800};
    b = {16'h3C00, 16'h4200, 16'h4000, 16'h3800, 16'hD640, 16'h3C00, 16'hC000, 16'h3400};
    drive(1'b0, 2'd0, 4'd0, a, b, "R1");
    // R4 subnormals
    a = {16'h0001, 16'h03FF, 16'h8001, 16'h0400, 16'h0200, 16'h83FF, 16'h0010, 16'h0401};
    b = {16'h0001, 16'h0001, 16'h0002, 16'h8001, 16'h0200, 16'h8001, 16'h8020, 16'h8400};
    drive(1'b0, 2'd0, 4'd0, a, b, "R4");
    // R5 zeros
    a = {16'h3C00, 16'h8000, 16'h0000, 16'h0000, 16'h3C00, 16'h8000, 16'h0000, 16'h0000};
    b = {16'hBC00, 16'h8000, 16'h8000, 16'h0000, 16'hBC00, 16'h8000, 16'h8000, 16'h0000};
    drive(1'b0, 2'd0, 4'd0, a, b, "R5");
    drive(1'b0, 2'd2, 4'd0, a, b, "R5");
    // R2 pairwise
    a = {16'h3C00, 16'h4000, 16'h4200, 16'h4400, 16'h0001, 16'h0001, 16'hBC00, 16'h3C00};
    b = {16'h4800, 16'h4900, 16'hC000, 16'h3800, 16'h7BFF, 16'h0000, 16'h5000, 16'h5000};
    drive(1'b1, 2'd0, 4'd0, a, b, "R2");
    // R3 ties and rounding direction per mode
    a = {16'h3C00, 16'hBC00, 16'h3C01, 16'hBC01, 16'h4000, 16'hC000, 16'h3C00, 16'hBC00};
    b = {16'h1000, 16'h9000, 16'h1000, 16'h9000, 16'h1001, 16'h9001, 16'h0C00, 16'h8C00};
    for (int r = 0; r < 4; r++) drive(1'b0, 2'(r), 4'd0, a, b, "R3");
    // R6 NaN and infinity
    a = {16'h7C01, 16'h7E00, 16'h7C00, 16'h7C00, 16'hFC00, 16'h3C00, 16'hFC00, 16'h7C00};
    b = {16'h3C00, 16'h3C00, 16'hFC00, 16'h3C00, 16'h7BFF, 16'hFD55, 16'hFC00, 16'h7C00};
    drive(1'b0, 2'd0, 4'd0, a, b, "R6");
    // R7 overflow in each mode
    a = {16'h7BFF, 16'hFBFF, 16'h7BFF, 16'hFBFF, 16'h7BF0, 16'hFBF0, 16'h3C00, 16'h3C00};
    b = {16'h7BFF, 16'hFBFF, 16'h5000, 16'hD000, 16'h6000, 16'hE000, 16'h3C00, 16'h3C00};
    for (int r = 0; r < 4; r++) drive(1'b0, 2'(r), 4'd0, a, b, "R7");
    // R9 trapped overflow and invalid, fresh flags via reset
    @(negedge clk); @(negedge clk);
    rst = 1'b1; @(negedge clk); rst = 1'b0; flag_model = 4'd0;
    drive(1'b0, 2'd0, 4'b0010, rep(16'h7BFF), rep(16'h7BFF), "R9");
    drive(1'b0, 2'd0, 4'b0001, rep(16'h7C01), rep(16'h3C00), "R9");
    drive(1'b0, 2'd0, 4'b1000, rep(16'h3C00), rep(16'h3C00), "R9");
    drive(1'b0, 2'd0, 4'b1001, rep(16'h3C00), rep(16'h1001), "R9");
    // R8 idle cycles keep flags
    @(negedge clk); @(negedge clk);
    check("R8", "flags held while idle", 128'(flags), 128'(flag_model));
    // random lanes, both pairings, all modes
    for (int n = 0; n < 400; n++) begin
      logic m;
      for (int l = 0; l < 4; l++) begin
        a[32*l +: 32] = $urandom;
        b[32*l +: 32] = $urandom;
      end
      m = n[0];
      drive(m, 2'(n >> 1), (n % 7 == 0) ? 4'($urandom) : 4'd0, a, b, m ? "R2" : "R1");
    end
    repeat (4) @(negedge clk);
    check("R10", "no pending results", 128'(sb.size()), 128'd0);
    check("R10", "valid low when idle", 128'(out_valid), 128'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule